// File: doc/BRIEF.md
# Enable-Gated Address Window Decoder

This block keeps the configuration of three physical address windows and decides, for each address presented on its lookup port, which window it falls in. Two windows are general memory-mapped ranges whose base and size come from a base register and a mask register. The third is a register-space window that has a base register and a fixed size of 4 KB. An enable register switches each window on or off. A lookup reports a one-hot hit and the byte offset of the address inside the winning window.

Software programs the registers through a write-only port that accepts only aligned 8-byte accesses. Every write register keeps only the bits that the decode uses. The block raises a one-cycle error pulse in four cases: a base or mask register is changed while its window is live, a write targets an index with no register, a write has the wrong size, or a write is misaligned. At reset the register defaults are computed from the chip and unit index inputs, so each instance comes up with its own distinct, non-overlapping ranges. All windows are disabled at reset.

Top module: `addr_window_decoder`

## Requirements
- R1: While reset is low, the registers load their defaults (byte values before the left shift by 14). MMIO0 base is 0x3d00000000000 + 0x4000000000·chip + 0x1000000000·unit. MMIO1 base is 0x3ff8000000000 + 0x200000000·chip + 0x80000000·unit. Register-space base is 0x3fffe40000000 + 0x400000·chip + 0x100000·unit. The MMIO0 mask is 0x3fff000000000 and the MMIO1 mask is 0x3ffff80000000, each stored shifted left by 14. The enable register clears, and hit, offset and error read zero.
- R2: A write is taken only when wr_bytes equals 8 and wr_addr[2:0] is zero. The register index is wr_addr shifted right by 3: 0 is MMIO0 base, 1 is MMIO1 base, 2 is MMIO0 mask, 3 is MMIO1 mask, 4 is register-space base and 5 is enable. A write of any other size or alignment stores nothing and pulses the error.
- R3: Writes to the four MMIO base and mask registers keep bits 63:30 and clear bits 29:0.
- R4: Writes to the register-space base keep bits 63:26 and clear bits 25:0.
- R5: Writes to the enable register keep bits 63:59. Bit 63 enables MMIO0, bit 62 enables MMIO1 and bit 61 enables register space.
- R6: A window's base is its stored base register shifted right by 14. An MMIO window's size is the inverse of its stored mask shifted right by 14, plus one. The register-space size is 0x1000.
- R7: An enabled window is hit when base ≤ address < base + size. The hit is hit[0] for MMIO0, hit[1] for MMIO1 and hit[2] for register space. win_offset is address minus the winning base, or zero with no hit. Both outputs appear on the clock edge after the address is presented.
- R8: When windows overlap, MMIO0 wins over MMIO1, which wins over register space. At most one hit bit is set.
- R9: An error pulses in two cases: an MMIO base or mask write while MMIO0 or MMIO1 is enabled, or a register-space base write while register space is enabled. The new value is still stored. Writes to the enable register never raise this error.
- R10: A write to index 6 or 7 stores nothing and pulses the error. Every error pulse lasts one cycle and appears on the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, loads defaults |
| chip_id | input | CHIP_W | Chip index used by the reset defaults |
| unit_id | input | UNIT_W | Unit index used by the reset defaults |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | AW | Byte address of the write |
| wr_bytes | input | 4 | Access size in bytes |
| wr_data | input | 64 | Write data |
| lookup_addr | input | 64 | Physical address to decode |
| hit | output | 3 | One-hot window hit, registered |
| win_offset | output | 64 | Offset inside the hit window, registered |
| wr_err | output | 1 | One-cycle error pulse for a rejected or unsafe write |

## Verification
The decode is swept over every chip and unit index after reset. Four addresses are probed at each default window: the base minus one, the base, the last byte and the first byte past the end. This separates errors in the default arithmetic, in the shift by 14 and in the size formula, including off-by-one at either edge. A second pattern places all three windows on one base and removes enables one at a time, which exposes the priority order and the enable bit positions. A third pattern writes values with their low bits set, and also writes bad indices, bad sizes and writes to live windows. The resulting window edges show whether the write masking, the store suppression and the error conditions each behave as specified.

// File: rtl/addr_window_decoder.sv
`timescale 1ns/1ps
module addr_window_decoder #(
  parameter int CHIP_W = 3,
  parameter int UNIT_W = 2,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHIP_W-1:0] chip_id,
  input  logic [UNIT_W-1:0] unit_id,
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_addr,
  input  logic [3:0]        wr_bytes,
  input  logic [63:0]       wr_data,
  input  logic [63:0]       lookup_addr,
  output logic [2:0]        hit,
  output logic [63:0]       win_offset,
  output logic              wr_err
);
  localparam int IDX_W = AW - 3;
  localparam logic [IDX_W-1:0] I_MB0 = IDX_W'(0), I_MB1 = IDX_W'(1),
                               I_MK0 = IDX_W'(2), I_MK1 = IDX_W'(3),
                               I_RB  = IDX_W'(4), I_EN  = IDX_W'(5);

  logic [33:0] mb0, mb1, mk0, mk1;
  logic [37:0] rb;
  logic [4:0]  en_r;

  logic [IDX_W-1:0] idx;
  logic             acc_ok, take;
  assign idx    = wr_addr[AW-1:3];
  assign acc_ok = (wr_bytes == 4'd8) && (wr_addr[2:0] == 3'd0);
  assign take   = wr_valid && acc_ok;

  logic [33:0] d_mb0, d_mb1;
  logic [37:0] d_rb;
  assign d_mb0 = 34'h3d0000000 + 34'(chip_id) * 34'h400000 + 34'(unit_id) * 34'h100000;
  assign d_mb1 = 34'h3ff800000 + 34'(chip_id) * 34'h20000  + 34'(unit_id) * 34'h8000;
  assign d_rb  = 38'h3fffe40000 + 38'(chip_id) * 38'h400 + 38'(unit_id) * 38'h100;

  logic unused_wdata;
  assign unused_wdata = &{1'b0, wr_data[25:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb0  <= d_mb0;
      mb1  <= d_mb1;
      rb   <= d_rb;
      mk0  <= 34'h3fff00000;
      mk1  <= 34'h3ffff8000;
      en_r <= '0;
    end else if (take) begin
      case (idx)
        I_MB0: mb0 <= wr_data[63:30];
        I_MB1: mb1 <= wr_data[63:30];
        I_MK0: mk0 <= wr_data[63:30];
        I_MK1: mk1 <= wr_data[63:30];
        I_RB:  rb  <= wr_data[63:26];
        I_EN:  en_r <= wr_data[63:59];
        default: ;
      endcase
    end
  end

  logic err_d;
  always_comb begin
    err_d = 1'b0;
    if (wr_valid) begin
      if (!acc_ok) err_d = 1'b1;
      else case (idx)
        I_MB0, I_MB1, I_MK0, I_MK1: err_d = en_r[4] | en_r[3];
        I_RB:  err_d = en_r[2];
        I_EN:  err_d = 1'b0;
        default: err_d = 1'b1;
      endcase
    end
  end

  logic [63:0] b0, b1, b2, s0, s1, o0, o1, o2;
  logic        in0, in1, in2;
  assign b0 = {14'b0, mb0, 16'b0};
  assign b1 = {14'b0, mb1, 16'b0};
  assign b2 = {14'b0, rb, 12'b0};
  assign s0 = {14'b0, ~mk0, 16'hffff} + 64'd1;
  assign s1 = {14'b0, ~mk1, 16'hffff} + 64'd1;
  assign o0 = lookup_addr - b0;
  assign o1 = lookup_addr - b1;
  assign o2 = lookup_addr - b2;
  assign in0 = en_r[4] && (lookup_addr >= b0) && (o0 < s0);
  assign in1 = en_r[3] && (lookup_addr >= b1) && (o1 < s1);
  assign in2 = en_r[2] && (lookup_addr >= b2) && (o2 < 64'h1000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit        <= '0;
      win_offset <= '0;
      wr_err     <= 1'b0;
    end else begin
      wr_err <= err_d;
      if (in0)      begin hit <= 3'b001; win_offset <= o0; end
      else if (in1) begin hit <= 3'b010; win_offset <= o1; end
      else if (in2) begin hit <= 3'b100; win_offset <= o2; end
      else          begin hit <= 3'b000; win_offset <= '0; end
    end
  end
endmodule

// File: rtl/addr_window_decoder_chk.sv
`timescale 1ns/1ps
module addr_window_decoder_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [3:0]    wr_bytes,
  input logic [2:0]    hit,
  input logic [63:0]   win_offset,
  input logic          wr_err,
  input logic [4:0]    en_r,
  input logic [33:0]   mb0
);
  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
  // R7
  miss_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == 3'b000) |-> (win_offset == 64'd0));
  // R6
  reg_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[2] |-> (win_offset < 64'h1000));
  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |-> $past(en_r[4]));
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_valid));
  // R2
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_bytes != 4'd8 || wr_addr[2:0] != 3'd0)) |=> ($stable(mb0) && $stable(en_r) && wr_err));
endmodule

bind addr_window_decoder addr_window_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_bytes(wr_bytes), .hit(hit), .win_offset(win_offset), .wr_err(wr_err),
  .en_r(en_r), .mb0(mb0)
);

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  chip_id = '0;
  logic [1:0]  unit_id = '0;
  logic        wr_valid = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [3:0]  wr_bytes = 4'd8;
  logic [63:0] wr_data = '0;
  logic [63:0] lookup_addr = '0;
  logic [2:0]  hit;
  logic [63:0] win_offset;
  logic        wr_err;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  addr_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .unit_id(unit_id),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_bytes(wr_bytes), .wr_data(wr_data),
    .lookup_addr(lookup_addr), .hit(hit), .win_offset(win_offset), .wr_err(wr_err)
  );

  localparam logic [63:0] EN_M0 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] EN_M1 = 64'h4000_0000_0000_0000;
  localparam logic [63:0] EN_RG = 64'h2000_0000_0000_0000;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(int idx, logic [63:0] d, logic [3:0] nb, bit exp_err, string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 6'(idx * 8); wr_bytes = nb; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_bytes = 4'd8;
    check(wr_err == exp_err, req, 64'(wr_err), 64'(exp_err));
  endtask

  task automatic probe(logic [63:0] a, logic [2:0] eh, logic [63:0] eo, string req);
    @(negedge clk); lookup_addr = a;
    @(negedge clk);
    check(hit == eh, req, 64'(hit), 64'(eh));
    check(win_offset == eo, req, win_offset, eo);
  endtask

  function automatic logic [63:0] msize(logic [63:0] m);
    logic [63:0] ms = m & 64'hffff_ffff_c000_0000;
    return ((~ms) >> 14) + 64'd1;
  endfunction

  task automatic edges(logic [63:0] b, logic [63:0] s, logic [2:0] h, string req);
    probe(b - 1, 3'b000, 64'd0, req);
    probe(b, h, 64'd0, req);
    probe(b + s - 1, h, s - 1, req);
    probe(b + s, 3'b000, 64'd0, req);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] base, s0, s1, m0, m1, rg;
    // R1 sweep of defaults across all chip/unit indices
    for (int c = 0; c < 8; c++) begin
      for (int u = 0; u < 4; u++) begin
        chip_id = 3'(c); unit_id = 2'(u);
        do_reset();
        m0 = 64'h3d00000000000 + 64'h4000000000 * 64'(c) + 64'h1000000000 * 64'(u);
        m1 = 64'h3ff8000000000 + 64'h200000000 * 64'(c) + 64'h80000000 * 64'(u);
        rg = 64'h3fffe40000000 + 64'h400000 * 64'(c) + 64'h100000 * 64'(u);
        s0 = msize(64'h3fff000000000 << 14);
        s1 = msize(64'h3ffff80000000 << 14);
        check(hit == 3'b000 && wr_err == 1'b0, "R1 reset outputs", {61'd0, hit}, 64'd0);
        probe(m0, 3'b000, 64'd0, "R1 disabled at reset");
        wr(5, EN_M0 | EN_M1 | EN_RG, 4'd8, 1'b0, "R5 enable write no error");
        edges(m0, s0, 3'b001, "R1 R6 R7 MMIO0 default");
        edges(m1, s1, 3'b010, "R1 R6 R7 MMIO1 default");
        edges(rg, 64'h1000, 3'b100, "R1 R6 R7 regspace default");
      end
    end

    chip_id = '0; unit_id = '0;
    do_reset();
    base = 64'h1_0000_0000;
    wr(0, base << 14, 4'd8, 1'b0, "R3 MMIO0 base");
    wr(1, base << 14, 4'd8, 1'b0, "R3 MMIO1 base");
    wr(2, 64'hffff_ffff_ffff_ffff & ~(64'hfffff << 14), 4'd8, 1'b0, "R3 MMIO0 mask");
    wr(3, 64'hffff_ffff_ffff_ffff & ~(64'hfffff << 14), 4'd8, 1'b0, "R3 MMIO1 mask");
    wr(4, base << 14, 4'd8, 1'b0, "R4 reg base");
    s0 = msize(64'hffff_ffff_ffff_ffff & ~(64'hfffff << 14));
    wr(5, EN_M0 | EN_M1 | EN_RG, 4'd8, 1'b0, "R5 enable all");
    probe(base + 64'h10, 3'b001, 64'h10, "R8 MMIO0 first");
    wr(5, EN_M1 | EN_RG, 4'd8, 1'b0, "R5 drop MMIO0");
    probe(base + 64'h10, 3'b010, 64'h10, "R8 MMIO1 over regspace");
    edges(base, s0, 3'b010, "R6 MMIO1 programmed size");
    wr(5, EN_RG, 4'd8, 1'b0, "R5 regspace only");
    edges(base, 64'h1000, 3'b100, "R6 R8 regspace alone");
    wr(5, 64'h07ff_ffff_ffff_ffff, 4'd8, 1'b0, "R5 low bits only");
    probe(base, 3'b000, 64'd0, "R5 low enable bits ignored");

    // R3 masking: low 30 bits discarded
    wr(0, (64'h2_0000_0000 << 14) | 64'h3fff_ffff, 4'd8, 1'b0, "R3 base write masked");
    wr(5, EN_M0, 4'd8, 1'b0, "R5 MMIO0 only");
    edges(64'h2_0000_0000, s0, 3'b001, "R3 low bits cleared");
    // R9 write while enabled: stored and flagged
    wr(1, 64'h3_0000_0000 << 14, 4'd8, 1'b1, "R9 MMIO1 base while MMIO live");
    wr(4, (64'h3_0000_0000 << 14) | 64'h3ff_ffff, 4'd8, 1'b0, "R9 reg base while reg off");
    wr(5, EN_M1 | EN_RG, 4'd8, 1'b0, "R5 MMIO1 and reg");
    probe(64'h3_0000_0000, 3'b010, 64'd0, "R9 value still stored");
    wr(5, EN_RG, 4'd8, 1'b0, "R5 reg only");
    edges(64'h3_0000_0000, 64'h1000, 3'b100, "R4 reg base low bits cleared");
    wr(4, 64'h4_0000_0000 << 14, 4'd8, 1'b1, "R9 reg base while reg live");
    probe(64'h4_0000_0000 + 64'h20, 3'b100, 64'h20, "R9 reg base stored");
    wr(0, 64'h5_0000_0000 << 14, 4'd8, 1'b0, "R9 MMIO write while only reg live");
    // R10 unknown indices
    wr(6, 64'hffff_ffff_ffff_ffff, 4'd8, 1'b1, "R10 index 6 error");
    wr(7, 64'hffff_ffff_ffff_ffff, 4'd8, 1'b1, "R10 index 7 error");
    probe(64'h4_0000_0000, 3'b100, 64'd0, "R10 nothing stored");
    // R2 size / alignment rejection
    wr(4, 64'h6_0000_0000 << 14, 4'd4, 1'b1, "R2 4-byte write rejected");
    probe(64'h4_0000_0000, 3'b100, 64'd0, "R2 4-byte write not stored");
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 6'd33; wr_bytes = 4'd8; wr_data = 64'h0;
    @(negedge clk);
    wr_valid = 1'b0;
    check(wr_err == 1'b1, "R2 misaligned error", 64'(wr_err), 64'd1);
    probe(64'h4_0000_0000, 3'b100, 64'd0, "R2 misaligned not stored");
    @(negedge clk);
    check(wr_err == 1'b0, "R10 pulse one cycle", 64'(wr_err), 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule